// File: doc/BRIEF.md
# Staged Watchdog Timer with Write Lock

This block is a watchdog timer that sits on a simple register write port and has a registered readback port. A programmable prescaler turns the system clock into ticks. A sequencer walks through up to four stages, counting ticks against each stage's timeout. When a stage runs out, the block takes that stage's action: nothing, a level interrupt, or a one-clock system reset request. It then moves on to the next stage. Software feeds the watchdog to send it back to the first stage.

Every write is dropped, feeds included, unless the key register holds the key value. Software normally unlocks the block, makes one change and locks it again. A common setup gives stage 0 the interrupt action and stage 1 the reset action. An unanswered interrupt then turns into a reset.

Top module: `staged_watchdog`

## Requirements
- R1: After reset, irq and sys_reset_req are low, the block is locked (the key address 7 reads 1), and the control (address 0) and divisor (address 1) registers read 0.
- R2: A write to any address other than 7, including a feed, has no effect unless the key register (address 7) holds the KEY parameter value. Writing any other value to address 7 locks the block. Address 7 reads 1 while locked and 0 while unlocked.
- R3: A write of any data to address 6 while unlocked returns the sequencer to stage 0 with a zero count and restarts the prescaler. The next stage-0 expiry therefore comes a full stage-0 period after the feed edge.
- R4: Control bit 0 enables counting. While it is clear, the tick count and the stage hold and no action fires. Setting the bit again resumes from the held count.
- R5: The divisor D at address 1 makes one tick every D clocks. The first tick comes D clocks after the edge that writes address 0 or 1. Stage k takes its timeout T from address 2+k and expires on its T-th tick.
- R6: The action of stage k is held in control bits [2k+2:2k+1]: 0 = off, 1 = interrupt, 2 = system reset, 3 = off. At expiry the sequencer moves to the next stage with a zero count, and the prescaler phase carries on without restarting.
- R7: A reset action sets sys_reset_req high for exactly one clock, starting at the edge of the expiring tick.
- R8: A stage whose action is off is skipped with no added delay. After the last stage, no further action fires until a feed.
- R9: An interrupt action sets a pending flag at the edge of the expiring tick. irq is high when the flag is set and control bit 9 is set. Writing address 0 with bit 10 set, while unlocked, clears the flag.
- R10: rd_data gives the stored value of the register at rd_addr one clock later. Control reads back bits [9:0], and address 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word address of the read |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| sys_reset_req | output | 1 | One-clock system reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, four stages and the default key. It programs divisors of 1 and 2 and timeouts of at most 5 ticks, so every expiry, feed and stage change falls within a few dozen clocks and can be checked on an exact cycle. Because the divisor and timeouts are software values, these small settings reach the same comparison and wrap paths that long timeouts would use.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NREG = 8;
  localparam int AW   = $clog2(NREG);
  localparam int NSTG = 4;

  localparam logic [AW-1:0] ADR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADR_DIV  = 3'd1;
  localparam logic [AW-1:0] ADR_TMO0 = 3'd2;
  localparam logic [AW-1:0] ADR_FEED = 3'd6;
  localparam logic [AW-1:0] ADR_KEY  = 3'd7;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_ACT_LSB = 1;
  localparam int CTRL_IE      = CTRL_ACT_LSB + 2 * NSTG;
  localparam int CTRL_CLR     = CTRL_IE + 1;
  localparam int CTRL_W       = CTRL_IE + 1;

  typedef enum logic [1:0] {
    ACT_OFF  = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_RST  = 2'd2,
    ACT_NONE = 2'd3
  } stage_act_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int          DW  = 32,
  parameter logic [31:0] KEY = 32'h50D83AA1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic                     en,
  output logic                     ie,
  output logic [NSTG-1:0][1:0]     act,
  output logic [DW-1:0]            div,
  output logic [NSTG-1:0][DW-1:0]  tmo,
  output logic                     feed_stb,
  output logic                     restart_stb,
  output logic                     clr_stb,
  output logic                     unlocked
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     div_q;
  logic [DW-1:0]     key_q;
  logic              acc;

  assign unlocked = (key_q == DW'(KEY));
  assign acc      = wr_en && (wr_addr == ADR_KEY || unlocked);

  assign en  = ctrl_q[CTRL_EN];
  assign ie  = ctrl_q[CTRL_IE];
  assign div = div_q;

  assign feed_stb    = acc && wr_addr == ADR_FEED;
  assign restart_stb = acc && (wr_addr == ADR_CTRL || wr_addr == ADR_DIV);
  assign clr_stb     = acc && wr_addr == ADR_CTRL && wr_data[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= '0;
      key_q  <= '0;
    end else if (acc) begin
      if (wr_addr == ADR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_addr == ADR_DIV)  div_q  <= wr_data;
      if (wr_addr == ADR_KEY)  key_q  <= wr_data;
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    logic [DW-1:0] tmo_q;
    always_ff @(posedge clk) begin
      if (rst) tmo_q <= '0;
      else if (acc && wr_addr == ADR_TMO0 + AW'(s)) tmo_q <= wr_data;
    end
    assign tmo[s] = tmo_q;
    assign act[s] = ctrl_q[CTRL_ACT_LSB + 2*s +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADR_CTRL: rd_data <= DW'(ctrl_q);
        ADR_DIV:  rd_data <= div_q;
        ADR_FEED: rd_data <= '0;
        ADR_KEY:  rd_data <= DW'(!unlocked);
        default:  rd_data <= tmo[rd_addr - ADR_TMO0];
      endcase
    end
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div,
  input  logic          restart,
  output logic          tick
);
  logic [DW-1:0] pre_q;
  logic [DW-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = en && (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (en)        pre_q <= tick ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_stage_seq.sv
module wdt_stage_seq
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int NS = NSTG,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  feed,
  input  logic [NS-1:0][1:0]    act,
  input  logic [NS-1:0][DW-1:0] tmo,
  output logic                  exp_irq,
  output logic                  exp_rst
);
  logic [SW-1:0] stg_q;
  logic [DW-1:0] cnt_q;
  logic          done_q;
  logic [SW-1:0] cur;
  logic          any;
  logic          hit;

  always_comb begin
    any = 1'b0;
    cur = stg_q;
    for (int i = NS - 1; i >= 0; i--) begin
      if (i >= int'(stg_q) && (act[i] == ACT_IRQ || act[i] == ACT_RST)) begin
        any = 1'b1;
        cur = SW'(i);
      end
    end
  end

  assign hit     = tick && !done_q && any &&
                   (({1'b0, cnt_q} + 1'b1) >= {1'b0, tmo[cur]});
  assign exp_irq = hit && act[cur] == ACT_IRQ;
  assign exp_rst = hit && act[cur] == ACT_RST;

  always_ff @(posedge clk) begin
    if (rst || feed) begin
      stg_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick && !done_q) begin
      if (!any) begin
        done_q <= 1'b1;
      end else if (hit) begin
        cnt_q <= '0;
        if (int'(cur) == NS - 1) done_q <= 1'b1;
        else                     stg_q  <= cur + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        stg_q <= cur;
      end
    end
  end
endmodule

// File: rtl/staged_watchdog.sv
module staged_watchdog
  import wdt_pkg::*;
#(
  parameter int          DW  = 32,
  parameter logic [31:0] KEY = 32'h50D83AA1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          sys_reset_req
);
  logic                    en_w, ie_w, feed_w, restart_w, clr_w, unl_w, tick_w;
  logic [NSTG-1:0][1:0]    act_w;
  logic [DW-1:0]           div_w;
  logic [NSTG-1:0][DW-1:0] tmo_w;
  logic                    exp_irq_w, exp_rst_w;
  logic                    pend_q, srr_q;

  wdt_regs #(.DW(DW), .KEY(KEY)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .en(en_w), .ie(ie_w), .act(act_w),
    .div(div_w), .tmo(tmo_w), .feed_stb(feed_w), .restart_stb(restart_w),
    .clr_stb(clr_w), .unlocked(unl_w)
  );

  wdt_prescale #(.DW(DW)) u_pre (
    .clk(clk), .rst(rst), .en(en_w), .div(div_w),
    .restart(restart_w || feed_w), .tick(tick_w)
  );

  wdt_stage_seq #(.DW(DW), .NS(NSTG)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_w), .feed(feed_w), .act(act_w),
    .tmo(tmo_w), .exp_irq(exp_irq_w), .exp_rst(exp_rst_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      srr_q  <= 1'b0;
    end else begin
      srr_q <= exp_rst_w;
      if (exp_irq_w)  pend_q <= 1'b1;
      else if (clr_w) pend_q <= 1'b0;
    end
  end

  assign irq           = pend_q && ie_w;
  assign sys_reset_req = srr_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          unlocked,
  input logic [DW-1:0] tmo0,
  input logic          en,
  input logic          feed,
  input logic          clr,
  input logic          exp_irq,
  input logic          irq,
  input logic          srr,
  input logic [SW-1:0] stg,
  input logic [DW-1:0] cnt
);
  assert_locked_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_TMO0 && !unlocked) |=> $stable(tmo0));

  assert_feed_restart_R3: assert property (@(posedge clk) disable iff (rst)
    feed |=> (stg == '0 && cnt == '0));

  assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !feed) |=> ($stable(cnt) && !srr));

  assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    srr |=> !srr);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !exp_irq) |=> !irq);
endmodule

bind staged_watchdog wdt_checker #(.DW(DW), .SW(2)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .unlocked(unl_w),
  .tmo0(tmo_w[0]), .en(en_w), .feed(feed_w), .clr(clr_w), .exp_irq(exp_irq_w),
  .irq(irq), .srr(sys_reset_req), .stg(u_seq.stg_q), .cnt(u_seq.cnt_q)
);

// File: tb/staged_watchdog_test.sv
module staged_watchdog_test;
  localparam logic [31:0] KEY = 32'h50D83AA1;
  localparam int NV = 9;
  // {addr, write data, expected readback of same addr}
  localparam logic [66:0] VEC [NV] = '{
    {3'd1, 32'd5,         32'd0},          // R2 locked write dropped
    {3'd7, KEY,           32'd0},          // R2 unlock
    {3'd1, 32'd5,         32'd5},          // R10
    {3'd2, 32'h1234,      32'h1234},       // R10
    {3'd7, 32'd0,         32'd1},          // R2 relock
    {3'd2, 32'd7,         32'h1234},       // R2 ignored
    {3'd7, 32'hDEAD,      32'd1},          // R2 wrong key
    {3'd7, KEY,           32'd0},          // R2
    {3'd5, 32'd9,         32'd9}           // R10
  };

  logic        clk = 0, rst = 1, wr_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        irq, sys_reset_req;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  staged_watchdog uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .sys_reset_req(sys_reset_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    step(2);
    rst = 0;
  endtask

  function automatic logic [31:0] mkc(input bit en, input logic [1:0] a0, a1, a2, a3,
                                      input bit ie, input bit clr);
    return 32'(en) | (32'(a0) << 1) | (32'(a1) << 3) | (32'(a2) << 5) |
           (32'(a3) << 7) | (32'(ie) << 9) | (32'(clr) << 10);
  endfunction

  task automatic cfg(input int d, t0, t1);
    wr(3'd7, KEY);
    wr(3'd1, 32'(d));
    wr(3'd2, 32'(t0));
    wr(3'd3, 32'(t1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int pulses;
    do_reset();
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 srr", 32'(sys_reset_req), 0);
    rd(3'd7, v); chk("R1 key", v, 1);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 div", v, 0);

    // R2/R10 vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], v);
      chk($sformatf("R2/R10 vec%0d", i), v, VEC[i][31:0]);
    end
    wr(3'd0, mkc(0, 2'd1, 2'd2, 2'd3, 2'd0, 1, 1));
    rd(3'd0, v); chk("R10 ctrl bits", v, mkc(0, 2'd1, 2'd2, 2'd3, 2'd0, 1, 0));

    // R5/R6/R7/R9 interrupt then reset
    do_reset();
    cfg(2, 3, 2);
    wr(3'd0, mkc(1, 2'd1, 2'd2, 2'd0, 2'd0, 1, 0));
    step(5); chk("R5 irq before expiry", 32'(irq), 0);
    step(1); chk("R5 R9 irq at expiry", 32'(irq), 1);
    step(3); chk("R6 srr before stage1 expiry", 32'(sys_reset_req), 0);
    step(1); chk("R6 R7 srr pulse", 32'(sys_reset_req), 1);
    step(1); chk("R7 srr one cycle", 32'(sys_reset_req), 0);
    wr(3'd0, mkc(1, 2'd1, 2'd2, 2'd0, 2'd0, 0, 0));
    chk("R9 irq masked", 32'(irq), 0);
    wr(3'd0, mkc(1, 2'd1, 2'd2, 2'd0, 2'd0, 1, 0));
    chk("R9 pending kept", 32'(irq), 1);
    wr(3'd0, mkc(1, 2'd1, 2'd2, 2'd0, 2'd0, 1, 1));
    chk("R9 cleared", 32'(irq), 0);
    pulses = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (sys_reset_req) pulses++; end
    chk("R8 idle after last stage", 32'(pulses + 32'(irq)), 0);

    // R3 feed restarts stage 0
    do_reset();
    cfg(2, 3, 0);
    wr(3'd0, mkc(1, 2'd1, 2'd0, 2'd0, 2'd0, 1, 0));
    step(3);
    wr(3'd6, 32'h0);
    step(2); chk("R3 no early irq", 32'(irq), 0);
    step(3); chk("R3 irq before restarted expiry", 32'(irq), 0);
    step(1); chk("R3 irq after full period", 32'(irq), 1);

    // R2 feed while locked is dropped
    do_reset();
    cfg(2, 3, 0);
    wr(3'd0, mkc(1, 2'd1, 2'd0, 2'd0, 2'd0, 1, 0));
    wr(3'd7, 32'h0);
    wr(3'd6, 32'h0);
    step(3); chk("R2 locked feed no early irq", 32'(irq), 0);
    step(1); chk("R2 locked feed ignored", 32'(irq), 1);

    // R8 off stage skipped
    do_reset();
    cfg(1, 5, 2);
    wr(3'd0, mkc(1, 2'd0, 2'd2, 2'd0, 2'd0, 0, 0));
    chk("R8 srr low", 32'(sys_reset_req), 0);
    step(1); chk("R8 srr low before skip expiry", 32'(sys_reset_req), 0);
    step(1); chk("R8 skipped stage adds no delay", 32'(sys_reset_req), 1);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (sys_reset_req) pulses++; end
    chk("R8 no further pulses", 32'(pulses), 0);

    // R4 disable holds count
    do_reset();
    cfg(1, 4, 0);
    wr(3'd0, mkc(1, 2'd1, 2'd0, 2'd0, 2'd0, 1, 0));
    step(2);
    wr(3'd0, mkc(0, 2'd1, 2'd0, 2'd0, 2'd0, 1, 0));
    step(10); chk("R4 no action while disabled", 32'(irq), 0);
    wr(3'd0, mkc(1, 2'd1, 2'd0, 2'd0, 2'd0, 1, 0));
    chk("R4 irq low at re-enable", 32'(irq), 0);
    step(1); chk("R4 resumes held count", 32'(irq), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule